// File: doc/BRIEF.md
# Processor Status and Mode Unit

This block keeps the live processor status word of a 32-bit RISC core together with one saved copy of that word for each exception mode. The live word carries four condition flags (negative, zero, carry, overflow), an IRQ mask, an FIQ mask and a five-bit mode field. The core's control logic drives single-cycle requests into the block:

- an exception entry naming the mode to enter;
- an exception return;
- a software write to the live word or to the saved word;
- a software read of the live word or of the saved word.

The block applies each request and reports any request it refuses.

A static two-bit width setting `{prog32, data32}` selects the operating regime:

| Setting | Program space | Data space | Address-range exceptions |
|---------|---------------|------------|--------------------------|
| 00 | 26-bit | 26-bit | enabled |
| 01 | 26-bit | 32-bit | disabled |
| 10 | undefined, raises a configuration error | | |
| 11 | 32-bit | 32-bit | disabled |

The width setting also limits which mode codes may become current. Refused requests leave all state unchanged and raise a one-cycle error pulse.

The saved words are kept in a small bank with one entry per privileged mode. The bank is indexed by the low mode bits, so the 26-bit and 32-bit variants of a mode share an entry. User mode has no bank entry.

Top module: `psr_mode_unit`

## Requirements
- R1: A synchronous reset sets the live word to supervisor mode (10011 when prog32 is 1, 00011 when it is 0), with both masks set and the flags cleared. Reset also clears every saved word to zero.
- R2: Status words use this layout: flags N,Z,C,V at bits 31:28, the IRQ mask at bit 7, the FIQ mask at bit 6 and the mode at bits 4:0. All other bits read as zero.
- R3: Legal modes depend on the width setting.
  - Setting 00 or 01: only 00000 user, 00001 FIQ, 00010 IRQ and 00011 supervisor are legal.
  - Setting 11: only 10000 user, 10001 FIQ, 10010 IRQ, 10011 supervisor, 10111 abort and 11011 undefined are legal.
  - Setting 10: no mode is legal.
- R4: An exception entry to a legal non-user mode copies the old live word into that mode's saved word and switches to the new mode. It sets the IRQ mask, sets the FIQ mask only when the target is an FIQ mode, and keeps the flags. An entry to an illegal or user target is refused.
- R5: An exception return copies the current mode's saved word into the live word. The return is refused when the current mode is user or when the restored mode is illegal.
- R6: Outside user mode, a live-word write loads flags, masks and mode. A write whose mode is illegal is refused.
- R7: In user mode, a live-word write changes only the flags, ignores the mask and mode bits, and raises no error.
- R8: Saved-word reads and writes address the current mode's entry. In user mode, a saved-word read returns zero and a saved-word write is ignored.
- R9: A read returns its value one cycle after the request. The value reflects the state before any update made in the same cycle. The read result holds its value while no read is requested.
- R10: When several requests arrive in one cycle, exception entry wins over return, and return wins over a write. Only the winning request takes effect.
- R11: `addr_exc_en_o` is 1 only for setting 00, and `cfg_err_o` is 1 only for setting 10. Both follow the setting with one cycle of delay.
- R12: Each saved word is independent. Changing the entry of one mode leaves the entries of the other modes unchanged.
- R13: Every refused request pulses `mode_err_o` for exactly one cycle. Accepted requests do not raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 2 | Static width setting {prog32, data32} |
| exc_req | input | 1 | Exception entry request |
| exc_mode | input | 5 | Mode code to enter |
| ret_req | input | 1 | Exception return request |
| wr_en | input | 1 | Status write request |
| wr_spsr | input | 1 | Write target: 1 = saved word, 0 = live word |
| wr_data | input | 32 | Write value in the R2 layout |
| rd_en | input | 1 | Status read request |
| rd_spsr | input | 1 | Read source: 1 = saved word, 0 = live word |
| rd_data | output | 32 | Registered read result |
| mode_o | output | 5 | Current mode |
| flags_o | output | 4 | Condition flags N,Z,C,V |
| irq_mask_o | output | 1 | IRQ mask |
| fiq_mask_o | output | 1 | FIQ mask |
| addr_exc_en_o | output | 1 | Address-range exceptions enabled |
| cfg_err_o | output | 1 | Undefined width setting |
| mode_err_o | output | 1 | One-cycle pulse on a refused request |

## Verification
The in-design assertions check the following on every cycle:
- the current mode stays legal under a steady setting;
- an accepted exception entry lands in the requested mode with the IRQ mask set;
- a user-mode write leaves the mode and masks untouched;
- a live-word write with an illegal mode is refused and flagged.

The bench covers what needs history across many cycles. It sweeps all 32 exception targets under all four settings and checks the saved-word contents by reading them back after entry. It also checks the priority of requests that arrive together, the independence of bank entries across nested entries and returns, and the zero reads in user mode.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int WORD_W     = 32;
  localparam int MODE_W     = 5;
  localparam int FLAG_W     = 4;
  localparam int BANK_DEPTH = 5;
  localparam int BANK_IDX_W = $clog2(BANK_DEPTH);

  localparam logic [MODE_W-1:0] MODE_SVC26 = 5'b00011;
  localparam logic [MODE_W-1:0] MODE_SVC32 = 5'b10011;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic              irq_m;
    logic              fiq_m;
    logic [MODE_W-1:0] mode;
  } psr_t;

  typedef struct packed {
    logic                  ok;
    logic [BANK_IDX_W-1:0] idx;
  } bank_sel_t;

  function automatic psr_t to_psr(input logic [WORD_W-1:0] w);
    psr_t p;
    p.flags = w[WORD_W-1 -: FLAG_W];
    p.irq_m = w[7];
    p.fiq_m = w[6];
    p.mode  = w[MODE_W-1:0];
    return p;
  endfunction

  function automatic logic [WORD_W-1:0] from_psr(input psr_t p);
    logic [WORD_W-1:0] w;
    w = '0;
    w[WORD_W-1 -: FLAG_W] = p.flags;
    w[7] = p.irq_m;
    w[6] = p.fiq_m;
    w[MODE_W-1:0] = p.mode;
    return w;
  endfunction

  function automatic logic mode_legal(input logic [MODE_W-1:0] m, input logic [1:0] cfg);
    logic ok;
    case (cfg)
      2'b00, 2'b01: ok = (m[4:2] == 3'b000);
      2'b11: ok = (m == 5'b10000) || (m == 5'b10001) || (m == 5'b10010) ||
                  (m == 5'b10011) || (m == 5'b10111) || (m == 5'b11011);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic is_user(input logic [3:0] low);
    return low == 4'b0000;
  endfunction

  function automatic bank_sel_t bank_of(input logic [3:0] low);
    bank_sel_t b;
    b.ok = 1'b1;
    case (low)
      4'b0001: b.idx = BANK_IDX_W'(0);
      4'b0010: b.idx = BANK_IDX_W'(1);
      4'b0011: b.idx = BANK_IDX_W'(2);
      4'b0111: b.idx = BANK_IDX_W'(3);
      4'b1011: b.idx = BANK_IDX_W'(4);
      default: begin
        b.ok  = 1'b0;
        b.idx = '0;
      end
    endcase
    return b;
  endfunction
endpackage

// File: rtl/psr_spsr_bank.sv
module psr_spsr_bank #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 5,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] entry_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        entry_q[i] <= '0;
      end else if (we && (widx == IDX_W'(i))) begin
        entry_q[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (ridx == IDX_W'(k)) rdata = entry_q[k];
    end
  end
endmodule

// File: rtl/psr_cfg_decode.sv
module psr_cfg_decode #(
  parameter int CFG_W = 2
) (
  input  logic             clk,
  input  logic [CFG_W-1:0] cfg,
  output logic             addr_exc_en,
  output logic             cfg_err
);
  always_ff @(posedge clk) begin
    addr_exc_en <= (cfg == CFG_W'(0));
    cfg_err     <= (cfg == CFG_W'(2));
  end

  // R11
  cfg_err_chk: assert property (@(posedge clk)
    ##1 (cfg_err |-> $past(cfg) == CFG_W'(2)));
endmodule

// File: rtl/psr_mode_unit.sv
module psr_mode_unit
  import psr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_width,
  input  logic                exc_req,
  input  logic [MODE_W-1:0]   exc_mode,
  input  logic                ret_req,
  input  logic                wr_en,
  input  logic                wr_spsr,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic                rd_spsr,
  output logic [WORD_W-1:0]   rd_data,
  output logic [MODE_W-1:0]   mode_o,
  output logic [FLAG_W-1:0]   flags_o,
  output logic                irq_mask_o,
  output logic                fiq_mask_o,
  output logic                addr_exc_en_o,
  output logic                cfg_err_o,
  output logic                mode_err_o
);
  psr_t      cpsr_q, cpsr_d;
  psr_t      bank_rd, bank_wd, wr_psr;
  logic      bank_we;
  logic [BANK_IDX_W-1:0] bank_widx;
  bank_sel_t cur_b, tgt_b;
  logic      cur_user, cur_legal;
  logic      exc_ok, ret_ok, wr_c, wr_c_user, wr_c_bad, wr_s;
  logic      err_d;
  logic      unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[WORD_W-FLAG_W-1:8], wr_data[5]};

  assign wr_psr    = to_psr(wr_data);
  assign cur_b     = bank_of(cpsr_q.mode[3:0]);
  assign tgt_b     = bank_of(exc_mode[3:0]);
  assign cur_user  = is_user(cpsr_q.mode[3:0]);
  assign cur_legal = mode_legal(cpsr_q.mode, cfg_width);

  // request arbitration: entry, then return, then write
  assign exc_ok    = exc_req && tgt_b.ok && mode_legal(exc_mode, cfg_width);
  assign ret_ok    = !exc_req && ret_req && cur_b.ok && mode_legal(bank_rd.mode, cfg_width);
  assign wr_c      = !exc_req && !ret_req && wr_en && !wr_spsr;
  assign wr_c_user = wr_c && cur_user;
  assign wr_c_bad  = wr_c && !cur_user && !mode_legal(wr_psr.mode, cfg_width);
  assign wr_s      = !exc_req && !ret_req && wr_en && wr_spsr && cur_b.ok;
  assign err_d     = (exc_req && !exc_ok) || (!exc_req && ret_req && !ret_ok) || wr_c_bad;

  assign bank_we   = exc_ok || wr_s;
  assign bank_widx = exc_ok ? tgt_b.idx : cur_b.idx;
  assign bank_wd   = exc_ok ? cpsr_q : wr_psr;

  psr_spsr_bank #(
    .WIDTH($bits(psr_t)),
    .DEPTH(BANK_DEPTH)
  ) u_bank (
    .clk  (clk),
    .rst  (rst),
    .we   (bank_we),
    .widx (bank_widx),
    .wdata(bank_wd),
    .ridx (cur_b.idx),
    .rdata(bank_rd)
  );

  psr_cfg_decode #(.CFG_W(2)) u_cfg (
    .clk        (clk),
    .cfg        (cfg_width),
    .addr_exc_en(addr_exc_en_o),
    .cfg_err    (cfg_err_o)
  );

  always_comb begin
    cpsr_d = cpsr_q;
    if (exc_ok) begin
      cpsr_d.mode  = exc_mode;
      cpsr_d.irq_m = 1'b1;
      if (exc_mode[3:0] == 4'b0001) cpsr_d.fiq_m = 1'b1;
    end else if (ret_ok) begin
      cpsr_d = bank_rd;
    end else if (wr_c_user) begin
      cpsr_d.flags = wr_psr.flags;
    end else if (wr_c && !wr_c_bad) begin
      cpsr_d = wr_psr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpsr_q.flags <= '0;
      cpsr_q.irq_m <= 1'b1;
      cpsr_q.fiq_m <= 1'b1;
      cpsr_q.mode  <= cfg_width[1] ? MODE_SVC32 : MODE_SVC26;
      rd_data      <= '0;
      mode_err_o   <= 1'b0;
    end else begin
      cpsr_q     <= cpsr_d;
      mode_err_o <= err_d;
      if (rd_en) begin
        if (!rd_spsr)      rd_data <= from_psr(cpsr_q);
        else if (cur_b.ok) rd_data <= from_psr(bank_rd);
        else               rd_data <= '0;
      end
    end
  end

  assign mode_o     = cpsr_q.mode;
  assign flags_o    = cpsr_q.flags;
  assign irq_mask_o = cpsr_q.irq_m;
  assign fiq_mask_o = cpsr_q.fiq_m;

  // R3
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_width != 2'b10 && $stable(cfg_width)) |-> cur_legal);

  // R4
  exc_entry_chk: assert property (@(posedge clk) disable iff (rst)
    exc_ok |=> (mode_o == $past(exc_mode) && irq_mask_o && flags_o == $past(flags_o)));

  // R7
  user_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_c_user |=> ($stable(mode_o) && $stable(irq_mask_o) && $stable(fiq_mask_o) && !mode_err_o));

  // R6
  bad_mode_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_c_bad |=> ($stable(mode_o) && $stable(flags_o) && mode_err_o));

  // R13
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!exc_req && !ret_req && !wr_en) |=> !mode_err_o);
endmodule

// File: tb/psr_mode_unit_test.sv
module psr_mode_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_width = 2'b00;
  logic        exc_req = 0, ret_req = 0, wr_en = 0, wr_spsr = 0, rd_en = 0, rd_spsr = 0;
  logic [4:0]  exc_mode = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [4:0]  mode_o;
  logic [3:0]  flags_o;
  logic        irq_mask_o, fiq_mask_o, addr_exc_en_o, cfg_err_o, mode_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state: {flags[3:0], irq, fiq, mode[4:0]}
  logic [10:0] m_cur;
  logic [10:0] m_bank [5];
  logic [31:0] m_rd;
  logic        m_err;

  always #4 clk = ~clk;

  psr_mode_unit uut (
    .clk(clk), .rst(rst), .cfg_width(cfg_width),
    .exc_req(exc_req), .exc_mode(exc_mode), .ret_req(ret_req),
    .wr_en(wr_en), .wr_spsr(wr_spsr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_spsr(rd_spsr), .rd_data(rd_data),
    .mode_o(mode_o), .flags_o(flags_o), .irq_mask_o(irq_mask_o), .fiq_mask_o(fiq_mask_o),
    .addr_exc_en_o(addr_exc_en_o), .cfg_err_o(cfg_err_o), .mode_err_o(mode_err_o)
  );

  function automatic logic [31:0] w32(input logic [10:0] s);
    return {s[10:7], 20'b0, s[6], s[5], 1'b0, s[4:0]};
  endfunction

  function automatic logic [10:0] s11(input logic [31:0] w);
    return {w[31:28], w[7], w[6], w[4:0]};
  endfunction

  function automatic bit legal(input logic [4:0] m, input logic [1:0] c);
    if (c == 2'b10) return 0;
    if (c == 2'b11) return m == 5'd16 || m == 5'd17 || m == 5'd18 || m == 5'd19 || m == 5'd23 || m == 5'd27;
    return m < 5'd4;
  endfunction

  function automatic int bidx(input logic [4:0] m);
    case (m[3:0])
      4'd1: return 0;
      4'd2: return 1;
      4'd3: return 2;
      4'd7: return 3;
      4'd11: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " state"}, w32({flags_o, irq_mask_o, fiq_mask_o, mode_o}), w32(m_cur));
    chk({tag, " R13 err"}, {31'b0, mode_err_o}, {31'b0, m_err});
    chk({tag, " R9 rd"}, rd_data, m_rd);
  endtask

  task automatic do_reset(input logic [1:0] c);
    cfg_width = c;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_cur = {4'b0, 1'b1, 1'b1, c[1] ? 5'b10011 : 5'b00011};
    for (int i = 0; i < 5; i++) m_bank[i] = '0;
    m_rd = '0;
    m_err = 0;
    check_all("R1 reset");
    chk("R11 addr_exc_en", {31'b0, addr_exc_en_o}, {31'b0, c == 2'b00});
    chk("R11 cfg_err", {31'b0, cfg_err_o}, {31'b0, c == 2'b10});
  endtask

  task automatic step(input bit exc, input logic [4:0] em, input bit ret,
                      input bit wr, input bit wsp, input logic [31:0] wd,
                      input bit rd, input bit rsp, input string tag);
    int b, t;
    logic [10:0] nw;
    exc_req = exc; exc_mode = em; ret_req = ret;
    wr_en = wr; wr_spsr = wsp; wr_data = wd; rd_en = rd; rd_spsr = rsp;
    b = bidx(m_cur[4:0]);
    m_err = 0;
    if (rd) m_rd = rsp ? ((b >= 0) ? w32(m_bank[b]) : 32'b0) : w32(m_cur);
    if (exc) begin
      t = bidx(em);
      if (legal(em, cfg_width) && t >= 0) begin
        m_bank[t] = m_cur;
        m_cur[4:0] = em;
        m_cur[6] = 1'b1;
        if (em[3:0] == 4'd1) m_cur[5] = 1'b1;
      end else m_err = 1;
    end else if (ret) begin
      if (b >= 0 && legal(m_bank[b][4:0], cfg_width)) m_cur = m_bank[b];
      else m_err = 1;
    end else if (wr) begin
      nw = s11(wd);
      if (wsp) begin
        if (b >= 0) m_bank[b] = nw;
      end else if (m_cur[3:0] == 4'd0) m_cur[10:7] = nw[10:7];
      else if (legal(nw[4:0], cfg_width)) m_cur = nw;
      else m_err = 1;
    end
    @(negedge clk);
    exc_req = 0; ret_req = 0; wr_en = 0; rd_en = 0;
    check_all(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      logic [4:0] base, svc;
      base = c[1] ? 5'b10000 : 5'b00000;
      svc = base | 5'd3;
      do_reset(2'(c));
      step(0, 0, 0, 0, 0, 0, 1, 1, "R1 saved cleared");
      // R3 R4 R5: sweep every exception target
      for (int t = 0; t < 32; t++) begin
        step(0, 0, 0, 1, 0, {4'(t), 20'hABCDE, 1'(t), 1'(t >> 1), 1'b1, svc}, 0, 0, "R6 setup");
        step(1, 5'(t), 0, 0, 0, 0, 0, 0, "R3 R4 entry");
        step(0, 0, 0, 0, 0, 0, 1, 1, "R4 R8 saved read");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R2 live read");
        step(0, 0, 1, 0, 0, 0, 0, 0, "R5 return");
      end
      // R10 priority
      step(1, base | 5'd2, 1, 1, 0, 32'hF000_0000 | svc, 0, 0, "R10 exc wins");
      step(0, 0, 1, 1, 0, 32'h5000_0000 | 32'(base | 5'd1), 0, 0, "R10 ret wins");
      // R6 illegal write and legal write
      step(0, 0, 0, 1, 0, 32'h3000_0000 | 32'd31, 1, 0, "R6 bad mode");
      step(0, 0, 0, 1, 0, 32'h9000_0000 | 32'(base), 1, 0, "R6 to user");
      // R7 user writes
      step(0, 0, 0, 1, 0, 32'hFFFF_FFFF, 1, 0, "R7 user write");
      step(0, 0, 0, 1, 1, 32'h7000_00C2, 1, 1, "R8 user saved write");
      step(0, 0, 0, 0, 0, 0, 1, 1, "R8 user saved read");
      step(0, 0, 1, 0, 0, 0, 0, 0, "R5 user return");
      // R12 nested banks
      step(1, base | 5'd2, 0, 0, 0, 0, 1, 1, "R12 enter irq");
      step(0, 0, 0, 1, 1, 32'h6000_0080 | 32'(svc), 1, 1, "R12 irq saved write");
      step(1, base | 5'd1, 0, 0, 0, 0, 1, 0, "R12 enter fiq");
      step(0, 0, 0, 0, 0, 0, 1, 1, "R12 fiq saved");
      step(0, 0, 1, 0, 0, 0, 1, 0, "R12 back to irq");
      step(0, 0, 0, 0, 0, 0, 1, 1, "R12 irq saved kept");
      step(0, 0, 0, 0, 0, 0, 0, 0, "R9 hold");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule